// File: doc/BRIEF.md
# Four-Phase Handshake Word Link

This block carries one data word at a time from a sending endpoint to a receiving endpoint over a request wire, an acknowledge wire and a data bus. It uses a return-to-zero protocol, so a transfer has four events. The sender raises request, and the receiver raises acknowledge. The sender then drops request, and the receiver drops acknowledge. The channel is idle only when both wires are low again. Each endpoint passes the other side's handshake wire through a two-stage synchronizer before its state machine uses it. This lets each side stall any phase for as long as it likes without breaking the protocol.

On the local side of the sender, a word-available input and a word bus are held until a one-cycle done pulse reports that the receiver has acknowledged the word. On the local side of the receiver, a readiness input allows the capture. A one-cycle strobe goes out together with the captured word. The channel wires are brought out as outputs so that the link can be observed.

Top module: `hs_link`

## Requirements
- R1: While rst_ni is low and after it is released, chan_req_o, chan_ack_o, tx_done_o and rx_strobe_o are all 0 until a word is offered.
- R2: chan_req_o rises only while tx_avail_i is 1, and only while chan_ack_o is 0. With tx_avail_i at 0, chan_req_o stays 0.
- R3: While chan_req_o is 1 and chan_ack_o is 0, chan_req_o stays 1 and chan_data_o holds the word that was loaded when request rose, which is tx_word_i at that edge.
- R4: chan_ack_o rises only while chan_req_o is 1, and only in a cycle where rx_ready_i was 1.
- R5: rx_strobe_o is 1 for exactly the one cycle that follows each rise of chan_ack_o. In that cycle rx_word_o equals chan_data_o.
- R6: chan_req_o falls only while chan_ack_o is 1. tx_done_o is 1 for exactly the one cycle in which chan_req_o has just fallen.
- R7: chan_ack_o falls only while chan_req_o is 0. After each transfer, both wires return to 0.
- R8: While rx_ready_i is 0 and chan_ack_o is 0, chan_ack_o stays 0 and no strobe is issued, however long the stall lasts.
- R9: Under stall lengths chosen at random on both sides, every word that is offered is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both endpoints |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_avail_i | input | 1 | Sender has a word; held until tx_done_o |
| tx_word_i | input | W | Word to send |
| tx_done_o | output | 1 | One-cycle pulse: word acknowledged |
| rx_ready_i | input | 1 | Receiver may consume a word |
| rx_word_o | output | W | Captured word |
| rx_strobe_o | output | 1 | One-cycle pulse: rx_word_o is new |
| chan_req_o | output | 1 | Channel request wire |
| chan_ack_o | output | 1 | Channel acknowledge wire |
| chan_data_o | output | W | Channel data bus |

## Verification
The properties assume that the upstream user keeps tx_avail_i and tx_word_i steady from the moment it offers a word until it sees tx_done_o. They also assume that rx_ready_i only gates the capture and is never needed for acknowledge to fall. The bench drives both local sides at falling edges. It holds the offered word until the done pulse, and it draws stall lengths from a vector table plus a small random spread. Because of this, every sequence it produces stays inside those assumptions.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_DRAIN} tx_state_e;
  typedef enum logic {RX_IDLE, RX_ACK} rx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_sender.sv
module hs_sender import hs_pkg::*; #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         avail_i,
  input  logic [W-1:0] word_i,
  input  logic         ack_i,
  output logic         req_o,
  output logic [W-1:0] data_o,
  output logic         done_o
);
  tx_state_e    state_q, state_d;
  logic         ack_s;
  logic [W-1:0] data_q;
  logic         done_q;

  hs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE:  if (avail_i && !ack_s) state_d = TX_REQ;
      TX_REQ:   if (ack_s) state_d = TX_DRAIN;
      TX_DRAIN: if (!ack_s) state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == TX_REQ) && ack_s;
      if (state_q == TX_IDLE && state_d == TX_REQ) data_q <= word_i;
    end
  end

  assign req_o  = (state_q == TX_REQ);
  assign data_o = data_q;
  assign done_o = done_q;
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver import hs_pkg::*; #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         ack_o,
  output logic [W-1:0] word_o,
  output logic         strobe_o
);
  rx_state_e    state_q;
  logic         req_s;
  logic [W-1:0] word_q;
  logic         strobe_q;

  hs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(req_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      word_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (req_s && ready_i) begin
          word_q   <= data_i;
          strobe_q <= 1'b1;
          state_q  <= RX_ACK;
        end
        RX_ACK: if (!req_s) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign ack_o    = (state_q == RX_ACK);
  assign word_o   = word_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/hs_link.sv
module hs_link #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_avail_i,
  input  logic [W-1:0] tx_word_i,
  output logic         tx_done_o,
  input  logic         rx_ready_i,
  output logic [W-1:0] rx_word_o,
  output logic         rx_strobe_o,
  output logic         chan_req_o,
  output logic         chan_ack_o,
  output logic [W-1:0] chan_data_o
);
  logic         req_w, ack_w;
  logic [W-1:0] data_w;

  hs_sender #(.W(W), .STAGES(STAGES)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .avail_i(tx_avail_i), .word_i(tx_word_i),
    .ack_i(ack_w), .req_o(req_w), .data_o(data_w), .done_o(tx_done_o)
  );

  hs_receiver #(.W(W), .STAGES(STAGES)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_w), .data_i(data_w),
    .ready_i(rx_ready_i), .ack_o(ack_w), .word_o(rx_word_o), .strobe_o(rx_strobe_o)
  );

  assign chan_req_o  = req_w;
  assign chan_ack_o  = ack_w;
  assign chan_data_o = data_w;
endmodule

// File: rtl/hs_link_chk.sv
module hs_link_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tx_avail_i,
  input logic         tx_done_o,
  input logic         rx_ready_i,
  input logic [W-1:0] rx_word_o,
  input logic         rx_strobe_o,
  input logic         chan_req_o,
  input logic         chan_ack_o,
  input logic [W-1:0] chan_data_o
);
  always_comb if (!rst_ni) AST_RESET_IDLE: assert (!chan_req_o && !chan_ack_o && !tx_done_o && !rx_strobe_o); // R1

  AST_REQ_RISE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_req_o) |-> $past(tx_avail_i) && !chan_ack_o); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_req_o && !chan_ack_o |=> chan_req_o && $stable(chan_data_o)); // R3
  AST_ACK_RISE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_ack_o) |-> chan_req_o && $past(rx_ready_i)); // R4
  AST_STROBE_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_ack_o) |-> rx_strobe_o); // R5
  AST_STROBE_ONLY_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_strobe_o |-> $rose(chan_ack_o) && rx_word_o == chan_data_o); // R5
  AST_REQ_FALL_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chan_req_o) |-> chan_ack_o && tx_done_o); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> $fell(chan_req_o)); // R6
  AST_ACK_FALL_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chan_ack_o) |-> !chan_req_o); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_i && !chan_ack_o |=> !chan_ack_o && !rx_strobe_o); // R8
endmodule

bind hs_link hs_link_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_avail_i(tx_avail_i), .tx_done_o(tx_done_o),
  .rx_ready_i(rx_ready_i), .rx_word_o(rx_word_o), .rx_strobe_o(rx_strobe_o),
  .chan_req_o(chan_req_o), .chan_ack_o(chan_ack_o), .chan_data_o(chan_data_o)
);

// File: tb/tb_hs_link.sv
`timescale 1ns/1ps
module tb_hs_link;
  localparam int W = 8;
  localparam int N = 8;
  // {word[15:8], tx_stall[7:4], rx_stall[3:0]}
  localparam logic [15:0] VEC [N] = '{
    16'h3C_00, 16'hA5_10, 16'h01_05, 16'hFF_F0,
    16'h80_0F, 16'h00_33, 16'h7E_92, 16'h5A_2B
  };

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         tx_avail_i = 1'b0, rx_ready_i = 1'b0;
  logic [W-1:0] tx_word_i = '0;
  logic         tx_done_o, rx_strobe_o, chan_req_o, chan_ack_o;
  logic [W-1:0] rx_word_o, chan_data_o;

  int n_cmp = 0, n_bad = 0, n_rx = 0, n_done = 0, cyc = 0;
  logic [W-1:0] rx_log [N+4];
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  hs_link #(.W(W)) dut (.*);

  always @(negedge clk_i) begin
    cyc++;
    if (rx_strobe_o) begin
      if (n_rx < N + 4) rx_log[n_rx] = rx_word_o;
      n_rx++;
    end
    if (tx_done_o) n_done++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 50000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic wait_done();
    do @(negedge clk_i); while (!tx_done_o);
  endtask

  initial begin
    int base_rx;
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {chan_req_o, chan_ack_o, tx_done_o, rx_strobe_o}, 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R1 idle after reset", {chan_req_o, chan_ack_o, tx_done_o, rx_strobe_o}, 0);
    chk("R2 no req without word", chan_req_o, 0);

    // R8: receiver stall
    tx_word_i = 8'hC3; tx_avail_i = 1'b1;
    repeat (25) @(negedge clk_i);
    chk("R8 ack held low", chan_ack_o, 0);
    chk("R8 no strobe", n_rx, 0);
    chk("R3 req held", chan_req_o, 1);
    chk("R3 data held", chan_data_o, 8'hC3);
    rx_ready_i = 1'b1;
    wait_done();
    tx_avail_i = 1'b0;
    repeat (12) @(negedge clk_i);
    chk("R5 word delivered", rx_log[0], 8'hC3);
    chk("R6 one done", n_done, 1);
    chk("R7 channel idle", {chan_req_o, chan_ack_o}, 0);
    rx_ready_i = 1'b0;

    // R9: table with random stall spread
    base_rx = n_rx;
    fork
      for (int i = 0; i < N; i++) begin
        repeat (int'(VEC[i][7:4]) + $urandom_range(0, 3)) @(negedge clk_i);
        tx_word_i = VEC[i][15:8]; tx_avail_i = 1'b1;
        wait_done();
        tx_avail_i = 1'b0;
      end
      for (int i = 0; i < N; i++) begin
        rx_ready_i = 1'b0;
        repeat (int'(VEC[i][3:0]) + $urandom_range(0, 3)) @(negedge clk_i);
        rx_ready_i = 1'b1;
        do @(negedge clk_i); while (!rx_strobe_o);
        rx_ready_i = 1'b0;
      end
    join
    repeat (15) @(negedge clk_i);
    for (int i = 0; i < N; i++) chk("R9 word order", rx_log[base_rx + i], VEC[i][15:8]);
    chk("R9 exactly once", n_rx, N + 1);
    chk("R6 done per word", n_done, N + 1);
    chk("R7 idle after run", {chan_req_o, chan_ack_o}, 0);

    // R2: no new request without a word, R4 no ack without request
    rx_ready_i = 1'b1;
    repeat (30) @(negedge clk_i);
    chk("R2 req stays low", chan_req_o, 0);
    chk("R4 ack stays low", chan_ack_o, 0);
    chk("R5 no extra strobe", n_rx, N + 1);
    finished = 1;
    summary();
  end
endmodule